// File: doc/BRIEF.md
# Multi-Destination Interrupt Priority Controller

This block gathers interrupt events from a set of on-chip peripheral sources and from a small group of external pins, and keeps one pending flag per source. Each source has an enable bit, a 4-bit priority level and a 2-bit route that picks a consumer: the processor, the data-transfer engine or the DMA engine. Enable bits only mask what a consumer sees. A flag that is set while its source is disabled stays set, and it reaches its consumer as soon as the source is enabled.

The processor and the data-transfer engine each get their own arbiter. It presents the pending, enabled, nonzero-priority source with the highest level, through registered valid, source ID and level outputs. Requests routed to the DMA engine are not arbitrated. Every qualifying one appears on its own request line, and the DMA engine chooses the order. A flag is cleared by a per-source clear strobe, by an acknowledge from the consumer that is currently being shown that source, or by a per-source DMA acknowledge. A new event in the same cycle as a clear takes priority over the clear.

Source numbering: peripheral input `p` is source `p`, and external pin `k` is source `N_PERIPH + k`.

Top module: `irq_route_ctrl`

## Requirements
- R1: A 1 on `periph_evt[p]` at a clock edge sets `pend_flags[p]` at that edge, whatever the value of `src_en[p]`.
- R2: External pins pass through a two-flop synchronizer and a rising-edge detector. A pin that rises before edge k sets its flag at edge k+2, and only when its `pin_en` bit is 1. A pin that stays high does not set the flag again.
- R3: `src_en` changes no flag. A flag set while its source is disabled stays set, and the source is presented one edge after it is enabled.
- R4: The processor outputs (`cpu_vld`, `cpu_id`, `cpu_lvl`) are registered one edge after the flags. They show the pending, enabled source with route code 0 and the highest nonzero level. When no such source exists, all three are 0. A level of 0 is never presented.
- R5: Between sources of equal level, the lower source index wins.
- R6: The data-transfer outputs (`dtc_vld`, `dtc_id`, `dtc_lvl`) follow the R4 rules, applied only to sources with route code 1, and are arbitrated independently of the processor outputs.
- R7: `dma_req[i]` is 1 in the same cycle as the flag whenever source i is pending, enabled, has route code 2 and has a nonzero level. All such sources are asserted at once.
- R8: A flag clears on `flag_clr[i]`, on `dma_ack[i]`, or on `cpu_ack`/`dtc_ack` while that consumer's valid output is 1 and its ID is i. If a set and a clear arrive at the same edge, the flag ends up set.
- R9: While `rst` is 1, all flags, synchronizer stages and registered outputs are 0.
- R10: A source with route code 3 never appears on any output, although its flag still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_evt | input | N_PERIPH | Peripheral event strobes |
| ext_pin | input | N_PIN | Asynchronous external interrupt pins |
| pin_en | input | N_PIN | Per-pin input enable |
| src_en | input | N_SRC | Per-source output enable |
| src_prio | input | N_SRC*4 | Per-source level, source i at bits [4i+3:4i] |
| src_dest | input | N_SRC*2 | Per-source route, 0 processor, 1 data-transfer, 2 DMA, 3 none |
| flag_clr | input | N_SRC | Per-source clear strobes |
| cpu_ack | input | 1 | Processor acknowledge of the presented source |
| dtc_ack | input | 1 | Data-transfer acknowledge of the presented source |
| dma_ack | input | N_SRC | Per-source DMA acknowledge |
| pend_flags | output | N_SRC | Pending flags |
| cpu_vld | output | 1 | Processor request valid |
| cpu_id | output | ID_W | Processor winning source |
| cpu_lvl | output | 4 | Processor winning level |
| dtc_vld | output | 1 | Data-transfer request valid |
| dtc_id | output | ID_W | Data-transfer winning source |
| dtc_lvl | output | 4 | Data-transfer winning level |
| dma_req | output | N_SRC | Unarbitrated DMA requests |

## Verification
A peripheral event shows up in `pend_flags` at the edge that samples it, and `dma_req` follows in the same cycle. The two arbitrated outputs lag the flags by exactly one more edge. A pin rise takes three edges to reach its flag. The bench drives inputs on the falling edge and steps its reference model on each rising edge, with the same register depths. It compares every output at the next falling edge. The directed checks wait exactly those one-, two- or three-edge delays before sampling.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PRIO_W = 4;
    localparam int DEST_W = 2;

    typedef enum logic [DEST_W-1:0] {
        ROUTE_CPU  = 2'd0,
        ROUTE_XFER = 2'd1,
        ROUTE_DMA  = 2'd2,
        ROUTE_OFF  = 2'd3
    } route_e;

    typedef logic [PRIO_W-1:0] level_t;

    function automatic route_e route_of(input logic [DEST_W-1:0] code);
        return route_e'(code);
    endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic pin_on,
    output logic rise
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], pin};
    end

    assign rise = sh[1] & ~sh[2] & pin_on;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= set_v | (pend & ~clr_v);
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N   = 12,
    parameter int IDW = 4
) (
    input  logic [N-1:0]        cand,
    input  logic [N*PRIO_W-1:0] lvl_flat,
    output logic                win_vld,
    output logic [IDW-1:0]      win_id,
    output level_t              win_lvl
);
    always_comb begin
        win_lvl = '0;
        win_id  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (lvl_flat[i*PRIO_W +: PRIO_W] > win_lvl)) begin
                win_lvl = lvl_flat[i*PRIO_W +: PRIO_W];
                win_id  = IDW'(i);
            end
        end
        win_vld = (win_lvl != '0);
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_pkg::*;
#(
    parameter int N_PERIPH = 8,
    parameter int N_PIN    = 4,
    parameter int N_SRC    = N_PERIPH + N_PIN,
    parameter int ID_W     = $clog2(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_PERIPH-1:0]     periph_evt,
    input  logic [N_PIN-1:0]        ext_pin,
    input  logic [N_PIN-1:0]        pin_en,
    input  logic [N_SRC-1:0]        src_en,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic [N_SRC*DEST_W-1:0] src_dest,
    input  logic [N_SRC-1:0]        flag_clr,
    input  logic                    cpu_ack,
    input  logic                    dtc_ack,
    input  logic [N_SRC-1:0]        dma_ack,
    output logic [N_SRC-1:0]        pend_flags,
    output logic                    cpu_vld,
    output logic [ID_W-1:0]         cpu_id,
    output logic [PRIO_W-1:0]       cpu_lvl,
    output logic                    dtc_vld,
    output logic [ID_W-1:0]         dtc_id,
    output logic [PRIO_W-1:0]       dtc_lvl,
    output logic [N_SRC-1:0]        dma_req
);
    localparam int N_ARB = 2;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
        level_t          lvl;
    } grant_t;

    logic [N_PIN-1:0] pin_rise;
    logic [N_SRC-1:0] set_v, clr_v, live;
    logic [N_SRC-1:0] cand [N_ARB];
    logic [N_SRC-1:0] ack_hit [N_ARB];
    grant_t           nxt [N_ARB];
    grant_t           cur [N_ARB];
    logic             ack_in [N_ARB];

    for (genvar k = 0; k < N_PIN; k++) begin : g_pin
        irq_pin_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .pin    (ext_pin[k]),
            .pin_on (pin_en[k]),
            .rise   (pin_rise[k])
        );
    end

    assign set_v = {pin_rise, periph_evt};

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign live[i]    = pend_flags[i] & src_en[i] &
                            (src_prio[i*PRIO_W +: PRIO_W] != '0);
        assign dma_req[i] = live[i] &
                            (route_of(src_dest[i*DEST_W +: DEST_W]) == ROUTE_DMA);
    end

    assign ack_in[0] = cpu_ack;
    assign ack_in[1] = dtc_ack;

    for (genvar d = 0; d < N_ARB; d++) begin : g_arb
        for (genvar i = 0; i < N_SRC; i++) begin : g_sel
            assign cand[d][i] = live[i] &
                (src_dest[i*DEST_W +: DEST_W] == DEST_W'(d));
            assign ack_hit[d][i] = ack_in[d] & cur[d].vld & (cur[d].id == ID_W'(i));
        end

        irq_arbiter #(.N(N_SRC), .IDW(ID_W)) u_arb (
            .cand     (cand[d]),
            .lvl_flat (src_prio),
            .win_vld  (nxt[d].vld),
            .win_id   (nxt[d].id),
            .win_lvl  (nxt[d].lvl)
        );

        always_ff @(posedge clk) begin
            if (rst) cur[d] <= '0;
            else     cur[d] <= nxt[d];
        end
    end

    assign clr_v = flag_clr | dma_ack | ack_hit[0] | ack_hit[1];

    irq_pend_bank #(.N(N_SRC)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .pend  (pend_flags)
    );

    assign cpu_vld = cur[0].vld;
    assign cpu_id  = cur[0].id;
    assign cpu_lvl = cur[0].lvl;
    assign dtc_vld = cur[1].vld;
    assign dtc_id  = cur[1].id;
    assign dtc_lvl = cur[1].lvl;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_pkg::*;
#(
    parameter int N_PERIPH = 8,
    parameter int N_PIN    = 4,
    parameter int N_SRC    = N_PERIPH + N_PIN,
    parameter int ID_W     = $clog2(N_SRC)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [N_PERIPH-1:0]     periph_evt,
    input logic [N_SRC-1:0]        src_en,
    input logic [N_SRC*PRIO_W-1:0] src_prio,
    input logic [N_SRC*DEST_W-1:0] src_dest,
    input logic [N_SRC-1:0]        pend_flags,
    input logic                    cpu_vld,
    input logic [ID_W-1:0]         cpu_id,
    input logic [PRIO_W-1:0]       cpu_lvl,
    input logic                    dtc_vld,
    input logic [ID_W-1:0]         dtc_id,
    input logic [N_SRC-1:0]        dma_req
);
    logic [N_SRC-1:0]        pend_q, en_q;
    logic [N_SRC*PRIO_W-1:0] prio_q;
    logic [N_SRC*DEST_W-1:0] dest_q;
    logic [N_PERIPH-1:0]     evt_q;
    logic [N_SRC-1:0]        off_mask;

    always_ff @(posedge clk) begin
        pend_q <= pend_flags;
        en_q   <= src_en;
        prio_q <= src_prio;
        dest_q <= src_dest;
        evt_q  <= rst ? '0 : periph_evt;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_off
        assign off_mask[i] = (src_dest[i*DEST_W +: DEST_W] == DEST_W'(3));
    end

    // R1
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_flags[N_PERIPH-1:0] & evt_q) == evt_q);

    // R4
    cpu_grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_vld |-> (pend_q[cpu_id] && en_q[cpu_id] &&
                     dest_q[cpu_id*DEST_W +: DEST_W] == DEST_W'(0) &&
                     cpu_lvl == prio_q[cpu_id*PRIO_W +: PRIO_W] && cpu_lvl != '0));

    // R6
    dtc_grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
        dtc_vld |-> (pend_q[dtc_id] && en_q[dtc_id] &&
                     dest_q[dtc_id*DEST_W +: DEST_W] == DEST_W'(1)));

    // R7
    dma_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_req & ~(pend_flags & src_en)) == '0);

    // R10
    off_route_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_req & off_mask) == '0);

    // R9
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (pend_flags == '0 && !cpu_vld && !dtc_vld));
endmodule

bind irq_route_ctrl irq_route_chk #(
    .N_PERIPH(N_PERIPH), .N_PIN(N_PIN), .N_SRC(N_SRC), .ID_W(ID_W)
) u_chk (
    .clk(clk), .rst(rst), .periph_evt(periph_evt), .src_en(src_en),
    .src_prio(src_prio), .src_dest(src_dest), .pend_flags(pend_flags),
    .cpu_vld(cpu_vld), .cpu_id(cpu_id), .cpu_lvl(cpu_lvl),
    .dtc_vld(dtc_vld), .dtc_id(dtc_id), .dma_req(dma_req)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
    localparam int NP = 8;
    localparam int NX = 4;
    localparam int N  = NP + NX;
    localparam int IW = $clog2(N);

    logic clk = 0, rst = 1;
    logic [NP-1:0]   periph_evt = '0;
    logic [NX-1:0]   ext_pin = '0, pin_en = '0;
    logic [N-1:0]    src_en = '0, flag_clr = '0, dma_ack = '0;
    logic [N*4-1:0]  src_prio = '0;
    logic [N*2-1:0]  src_dest = '0;
    logic            cpu_ack = 0, dtc_ack = 0;
    logic [N-1:0]    pend_flags, dma_req;
    logic            cpu_vld, dtc_vld;
    logic [IW-1:0]   cpu_id, dtc_id;
    logic [3:0]      cpu_lvl, dtc_lvl;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    irq_route_ctrl #(.N_PERIPH(NP), .N_PIN(NX)) u0 (.*);

    // behavioural reference
    bit m_pend [N];
    bit m_s1 [NX], m_s2 [NX], m_s3 [NX];
    int m_v [2], m_i [2], m_l [2];

    function automatic int prio_of(int i); return int'(src_prio[i*4 +: 4]); endfunction
    function automatic int dest_of(int i); return int'(src_dest[i*2 +: 2]); endfunction

    always @(posedge clk) begin
        int bi [2], bl [2];
        bit setb, clrb;
        if (rst) begin
            for (int i = 0; i < N; i++) m_pend[i] = 0;
            for (int k = 0; k < NX; k++) begin m_s1[k] = 0; m_s2[k] = 0; m_s3[k] = 0; end
            for (int d = 0; d < 2; d++) begin m_v[d] = 0; m_i[d] = 0; m_l[d] = 0; end
        end else begin
            for (int d = 0; d < 2; d++) begin
                bi[d] = 0; bl[d] = 0;
                for (int i = 0; i < N; i++)
                    if (m_pend[i] && src_en[i] && dest_of(i) == d && prio_of(i) > bl[d]) begin
                        bl[d] = prio_of(i); bi[d] = i;
                    end
            end
            for (int i = 0; i < N; i++) begin
                setb = (i < NP) ? periph_evt[i]
                     : (m_s2[i-NP] && !m_s3[i-NP] && pin_en[i-NP]);
                clrb = flag_clr[i] || dma_ack[i] ||
                       (cpu_ack && m_v[0] != 0 && m_i[0] == i) ||
                       (dtc_ack && m_v[1] != 0 && m_i[1] == i);
                if (setb) m_pend[i] = 1;
                else if (clrb) m_pend[i] = 0;
            end
            for (int k = 0; k < NX; k++) begin
                m_s3[k] = m_s2[k]; m_s2[k] = m_s1[k]; m_s1[k] = ext_pin[k];
            end
            for (int d = 0; d < 2; d++) begin
                m_v[d] = (bl[d] != 0); m_i[d] = bi[d]; m_l[d] = bl[d];
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        int ep, ed;
        if (!rst) begin
            ep = 0; ed = 0;
            for (int i = 0; i < N; i++) begin
                if (m_pend[i]) ep |= (1 << i);
                if (m_pend[i] && src_en[i] && dest_of(i) == 2 && prio_of(i) != 0) ed |= (1 << i);
            end
            chk("R1 pend_flags", int'(pend_flags), ep);
            chk("R4 cpu", int'({cpu_vld, cpu_id, cpu_lvl}),
                (m_v[0] << (IW+4)) | (m_i[0] << 4) | m_l[0]);
            chk("R6 dtc", int'({dtc_vld, dtc_id, dtc_lvl}),
                (m_v[1] << (IW+4)) | (m_i[1] << 4) | m_l[1]);
            chk("R7 dma_req", int'(dma_req), ed);
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(int i, int p, int d);
        src_prio[i*4 +: 4] = 4'(p);
        src_dest[i*2 +: 2] = 2'(d);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cfg(0,3,0); cfg(1,5,0); cfg(2,5,0); cfg(3,2,1); cfg(4,7,1); cfg(5,1,2);
        cfg(6,4,2); cfg(7,0,0); cfg(8,6,0); cfg(9,1,1); cfg(10,2,2); cfg(11,9,3);
        src_en = '1; src_en[4] = 0;
        step(3);
        chk("R9 reset flags", int'(pend_flags), 0);
        chk("R9 reset cpu_vld", int'(cpu_vld), 0);
        rst = 0;
        step(1);
        chk("R9 flags after release", int'(pend_flags), 0);

        // R1 / R4 single source
        periph_evt = 8'h01; step(1); periph_evt = '0;
        chk("R1 flag0 set", int'(pend_flags[0]), 1);
        step(1);
        chk("R4 cpu id0", int'({cpu_vld, cpu_id, cpu_lvl}), (1 << (IW+4)) | 3);
        cpu_ack = 1; step(1); cpu_ack = 0;
        chk("R8 ack clears flag0", int'(pend_flags[0]), 0);
        step(1);
        chk("R4 cpu idle", int'(cpu_vld), 0);

        // R5 tie
        periph_evt = 8'h06; step(2); periph_evt = '0;
        chk("R5 tie lower index", int'(cpu_id), 1);
        chk("R5 tie level", int'(cpu_lvl), 5);
        cpu_ack = 1; step(1); cpu_ack = 0; step(1);
        chk("R5 next winner", int'(cpu_id), 2);
        flag_clr[2] = 1; step(1); flag_clr = '0; step(1);
        chk("R8 strobe clear", int'(pend_flags), 0);

        // R3 mask holds flag
        periph_evt = 8'h10; step(1); periph_evt = '0; step(1);
        chk("R3 flag held while disabled", int'(pend_flags[4]), 1);
        chk("R3 masked dtc", int'(dtc_vld), 0);
        src_en[4] = 1; step(1);
        chk("R6 dtc id4", int'({dtc_vld, dtc_id, dtc_lvl}), (1 << (IW+4)) | (4 << 4) | 7);
        dtc_ack = 1; step(1); dtc_ack = 0; step(1);

        // R7 DMA
        periph_evt = 8'h60; step(1); periph_evt = '0;
        chk("R7 dma both", int'(dma_req), 12'h060);
        dma_ack = 12'h060; step(1); dma_ack = '0;
        chk("R8 dma ack", int'(dma_req), 0);

        // R2 pins
        pin_en = 4'b0001; ext_pin = 4'b0011;
        step(2);
        chk("R2 not yet", int'(pend_flags[8]), 0);
        step(1);
        chk("R2 pin0 set", int'(pend_flags[8]), 1);
        chk("R2 pin1 gated", int'(pend_flags[9]), 0);
        flag_clr[8] = 1; step(1); flag_clr = '0; step(3);
        chk("R2 level no reset", int'(pend_flags[8]), 0);
        ext_pin = '0; step(3);

        // R8 set beats clear
        periph_evt = 8'h01; flag_clr[0] = 1; step(1); periph_evt = '0; flag_clr = '0;
        chk("R8 set wins", int'(pend_flags[0]), 1);
        flag_clr[0] = 1; step(1); flag_clr = '0; step(1);

        // R10 / zero level
        periph_evt = 8'h80; step(1); periph_evt = '0;
        u_force11();
        step(2);
        chk("R10 flags held", int'(pend_flags[11] & pend_flags[7]), 1);
        chk("R10 no cpu", int'(cpu_vld), 0);
        chk("R10 no dma", int'(dma_req), 0);
        flag_clr = '1; step(1); flag_clr = '0; step(1);

        // random traffic
        for (int c = 0; c < 3000; c++) begin
            periph_evt = 8'($urandom) & 8'($urandom) & 8'($urandom);
            if ($urandom_range(0, 7) == 0) ext_pin = 4'($urandom);
            if ($urandom_range(0, 31) == 0) pin_en = 4'($urandom);
            if ($urandom_range(0, 31) == 0) src_en = 12'($urandom);
            flag_clr = ($urandom_range(0, 7) == 0) ? 12'(1 << $urandom_range(0, N-1)) : '0;
            dma_ack  = ($urandom_range(0, 3) == 0) ? dma_req : '0;
            cpu_ack  = cpu_vld && ($urandom_range(0, 2) == 0);
            dtc_ack  = dtc_vld && ($urandom_range(0, 2) == 0);
            step(1);
        end
        periph_evt = '0; flag_clr = '0; dma_ack = '0; cpu_ack = 0; dtc_ack = 0;
        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // source 11 is pin 3: raise it with its enable on
    task automatic u_force11();
        pin_en[3] = 1; ext_pin[3] = 1;
        step(3);
        ext_pin[3] = 0;
    endtask
endmodule